// File: doc/BRIEF.md
# Multiplexed Programming Register Interface

This block is the slave side of a memory programming port. An external programmer reaches it over one 8-bit bus that carries both addresses and data. A latch strobe, an active-low chip select, an active-low read and an active-low write control each transaction. The programmer first puts a register address on the bus and pulses the latch strobe. The address is taken when the strobe falls. The programmer then lowers chip select together with read or write. The block keeps a small bank of plain storage registers and one read-only status register. It drives the bus only while a valid read is in progress.

All pins are treated as asynchronous. Each passes through a two-stage synchroniser on the block clock, and every strobe edge is detected on the synchronised copy. That clock must run for the whole programming session.

An access is valid only if a fresh latch pulse has occurred since chip select was last released. If it has not, the access is refused and a sticky error bit in the status register is set. This catches programmers that skip the address phase. A high level on the synchronous reset input returns all state to its initial values.

Top module: `prog_reg_port`

## Requirements
- R1: While reset is high and afterwards, the bus enable is low, every storage register reads 0x00 and the status register reads 0x00.
- R2: The address is taken from the bus on the falling edge of the latch strobe. Addresses 0 to NUM_REGS-1 (default 0..3) select the storage registers.
- R3: After a latch pulse, lowering chip select and write stores the bus value in the addressed storage register, once per write assertion.
- R4: After a latch pulse, lowering chip select and read raises the bus enable and drives the addressed register's value on the bus output.
- R5: An access (read or write) made with no latch pulse since the last release of chip select is ignored: no register changes and the bus enable stays low.
- R6: Such an ignored access sets bit 0 of the status register at address STATUS_ADDR (default 7); the other status bits read 0. The bit stays set until reset.
- R7: If read and write are low at the same time, no register is written and the bus enable stays low.
- R8: The status register is read-only; writing to STATUS_ADDR changes nothing.
- R9: The bus enable drops no more than three clock cycles after the read or chip-select pin goes high. This is two synchroniser stages plus one output register.
- R10: Unmapped addresses (neither a storage register nor STATUS_ADDR) read as 0x00, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, running throughout programming |
| rstIn | input | 1 | Synchronous reset, active high |
| latchIn | input | 1 | Address latch strobe; address taken on its falling edge |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read control, active low |
| wrN | input | 1 | Write control, active low |
| busIn | input | 8 | Bus value seen at the pins (address or write data) |
| busOut | output | 8 | Read data to the pins |
| busOe | output | 1 | Bus driver enable for busOut |

## Verification
The bench targets these cases:
- An access that follows a chip-select release with no new latch pulse. A design that keeps the old address armed would store the data and raise no error.
- A write aimed at the status address. A design that treats the status register as storage would clear or corrupt the error bit.
- Read and write asserted together. A flawed design would either overwrite the register or drive the bus against the programmer.
- The error bit across later valid accesses, and the point where the bus enable drops after read rises. These expose a bit that clears itself, or an output enable that lingers past the three-cycle window.

// File: rtl/prog_port_pkg.sv
package prog_port_pkg;
  // Strobes from control to datapath, one clock wide except drive
  typedef struct packed {
    logic capAddr;  // take address from bus
    logic wrEn;     // store bus into addressed register
    logic errSet;   // flag a refused access
    logic drive;    // a valid read is active
  } strobe_t;
endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= INIT;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= INIT;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/prog_ctrl.sv
module prog_ctrl
  import prog_port_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    latchS,
  input  logic    csNs,
  input  logic    rdNs,
  input  logic    wrNs,
  output strobe_t strb
);
  logic latchPrev, csNPrev, rdNPrev, wrNPrev;
  logic armed;
  logic csAct, rdAct, wrAct;
  logic latchFall, csRelease, rdStart, wrStart;

  assign csAct     = !csNs;
  assign rdAct     = !rdNs;
  assign wrAct     = !wrNs;
  assign latchFall = latchPrev && !latchS;
  assign csRelease = !csNPrev && csNs;
  assign rdStart   = rdNPrev && !rdNs;
  assign wrStart   = wrNPrev && !wrNs;

  always_ff @(posedge clk) begin
    if (rst) begin
      latchPrev <= 1'b0;
      csNPrev   <= 1'b1;
      rdNPrev   <= 1'b1;
      wrNPrev   <= 1'b1;
    end else begin
      latchPrev <= latchS;
      csNPrev   <= csNs;
      rdNPrev   <= rdNs;
      wrNPrev   <= wrNs;
    end
  end

  // Armed by a latch pulse, disarmed whenever chip select is released
  always_ff @(posedge clk) begin
    if (rst)            armed <= 1'b0;
    else if (csRelease) armed <= 1'b0;
    else if (latchFall) armed <= 1'b1;
  end

  always_comb begin
    strb.capAddr = latchFall;
    strb.wrEn    = csAct && wrStart && !rdAct && armed;
    strb.errSet  = csAct && (rdStart || wrStart) && !armed;
    strb.drive   = csAct && rdAct && !wrAct && armed;
  end

  assert_both_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (!rdNs && !wrNs) |-> (!strb.wrEn && !strb.drive));
  assert_unarmed_silent_R5: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!strb.wrEn && !strb.drive));
  assert_disarm_on_release_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(csNs) |=> !armed);
endmodule

// File: rtl/prog_dpath.sv
module prog_dpath
  import prog_port_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] STATUS_ADDR = 8'd7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] busS,
  input  strobe_t       strb,
  output logic [DW-1:0] busOut,
  output logic          busOe
);
  logic [DW-1:0] addrQ;
  logic [DW-1:0] regs [NUM_REGS];
  logic          errFlag;
  logic [DW-1:0] readVal;

  always_ff @(posedge clk) begin
    if (rst)               addrQ <= '0;
    else if (strb.capAddr) addrQ <= busS;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) regs[g] <= '0;
        else if (strb.wrEn && addrQ == DW'(g)) regs[g] <= busS;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)              errFlag <= 1'b0;
    else if (strb.errSet) errFlag <= 1'b1;
  end

  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addrQ == DW'(i)) readVal = regs[i];
    if (addrQ == STATUS_ADDR) readVal = {{(DW-1){1'b0}}, errFlag};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busOe  <= 1'b0;
      busOut <= '0;
    end else begin
      busOe  <= strb.drive;
      busOut <= strb.drive ? readVal : '0;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rstIsHigh() |=> (!busOe && !errFlag));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);
  assert_status_readonly_R8: assert property (@(posedge clk) disable iff (rst)
    (strb.wrEn && addrQ == STATUS_ADDR) |=> (errFlag == $past(errFlag)));
  assert_excl_strobes_R5: assert property (@(posedge clk) disable iff (rst)
    !(strb.wrEn && strb.errSet));

  function automatic logic rstIsHigh();
    return rst;
  endfunction
endmodule

// File: rtl/prog_reg_port.sv
module prog_reg_port
  import prog_port_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] STATUS_ADDR = 8'd7,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstIn,
  input  logic          latchIn,
  input  logic          csN,
  input  logic          rdN,
  input  logic          wrN,
  input  logic [DW-1:0] busIn,
  output logic [DW-1:0] busOut,
  output logic          busOe
);
  logic [3:0]    ctlS;
  logic [DW-1:0] busS;
  strobe_t       strb;

  prog_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b1110)) u_ctlSync (
    .clk(clk), .rst(rstIn), .d({csN, rdN, wrN, latchIn}), .q(ctlS));

  prog_sync #(.W(DW), .STAGES(SYNC_STAGES), .INIT('0)) u_busSync (
    .clk(clk), .rst(rstIn), .d(busIn), .q(busS));

  prog_ctrl u_ctrl (
    .clk(clk), .rst(rstIn), .latchS(ctlS[0]), .csNs(ctlS[3]),
    .rdNs(ctlS[2]), .wrNs(ctlS[1]), .strb(strb));

  prog_dpath #(.NUM_REGS(NUM_REGS), .DW(DW), .STATUS_ADDR(STATUS_ADDR)) u_dpath (
    .clk(clk), .rst(rstIn), .busS(busS), .strb(strb),
    .busOut(busOut), .busOe(busOe));

  assert_oe_release_R9: assert property (@(posedge clk) disable iff (rstIn)
    ($rose(ctlS[2]) || $rose(ctlS[3])) |=> !busOe);
endmodule

// File: tb/sim_prog_reg_port.sv
module sim_prog_reg_port;
  logic clk = 1'b0;
  logic rstIn = 1'b1;
  logic latchIn = 1'b0, csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [7:0] busIn = 8'h00;
  logic [7:0] busOut;
  logic busOe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic       oe;
    logic [7:0] val;
  } exp_t;
  exp_t expQ[$];
  event sampleEv;

  always #10 clk = ~clk;

  prog_reg_port u0 (
    .clk(clk), .rstIn(rstIn), .latchIn(latchIn), .csN(csN), .rdN(rdN),
    .wrN(wrN), .busIn(busIn), .busOut(busOut), .busOe(busOe));

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expected item each time the driver marks a sample point
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        if (e.oe) check(e.tag, {busOe, busOut}, {1'b1, e.val});
        else      check(e.tag, {busOe, 8'h00}, {1'b0, 8'h00});
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latchAddr(logic [7:0] a);
    busIn = a; latchIn = 1'b1; cyc(3);
    latchIn = 1'b0; cyc(4);
  endtask

  task automatic writeAcc(logic [7:0] d);
    busIn = d; cyc(2);
    csN = 1'b0; wrN = 1'b0; cyc(4);
    wrN = 1'b1; cyc(2);
    csN = 1'b1; cyc(4);
  endtask

  task automatic readAcc(string tag, logic expOe, logic [7:0] val);
    exp_t e;
    csN = 1'b0; rdN = 1'b0; cyc(5);
    e.tag = tag; e.oe = expOe; e.val = val;
    expQ.push_back(e);
    -> sampleEv;
    cyc(1);
    rdN = 1'b1;
    if (expOe) begin
      cyc(3);
      check("R9 enable release", {8'h00, busOe}, 9'h000);
    end else cyc(3);
    csN = 1'b1; cyc(4);
  endtask

  task automatic writeReg(logic [7:0] a, logic [7:0] d);
    latchAddr(a); writeAcc(d);
  endtask

  task automatic readReg(string tag, logic [7:0] a, logic [7:0] val);
    latchAddr(a); readAcc(tag, 1'b1, val);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    cyc(4);
    check("R1 enable in reset", {8'h00, busOe}, 9'h000);
    rstIn = 1'b0; cyc(3);

    for (int i = 0; i < 4; i++) readReg("R1 reg after reset", 8'(i), 8'h00);
    readReg("R1 status after reset", 8'd7, 8'h00);

    writeReg(8'd1, 8'hA5);
    writeReg(8'd2, 8'h3C);
    writeReg(8'd3, 8'h5A);
    readReg("R3 R4 reg1", 8'd1, 8'hA5);
    readReg("R2 reg2", 8'd2, 8'h3C);
    readReg("R2 reg3", 8'd3, 8'h5A);
    readReg("R2 reg0 untouched", 8'd0, 8'h00);

    writeReg(8'd7, 8'hFF);
    readReg("R8 status write ignored", 8'd7, 8'h00);

    writeReg(8'd5, 8'h77);
    readReg("R10 unmapped 5", 8'd5, 8'h00);
    readReg("R10 unmapped 200", 8'd200, 8'h00);

    // Read and write together
    latchAddr(8'd1);
    busIn = 8'h11; cyc(2);
    csN = 1'b0; rdN = 1'b0; wrN = 1'b0; cyc(5);
    begin exp_t e; e.tag = "R7 no drive"; e.oe = 1'b0; e.val = 8'h00;
      expQ.push_back(e); -> sampleEv; end
    cyc(1);
    rdN = 1'b1; wrN = 1'b1; cyc(2); csN = 1'b1; cyc(4);
    readReg("R7 reg1 kept", 8'd1, 8'hA5);
    readReg("R6 status clear before error", 8'd7, 8'h00);

    // Write with no fresh latch pulse
    writeAcc(8'h99);
    readReg("R5 reg2 unchanged", 8'd2, 8'h3C);
    readReg("R5 reg7 no write", 8'd7, 8'h01);
    // Read with no fresh latch pulse
    readAcc("R5 unarmed read", 1'b0, 8'h00);
    writeReg(8'd0, 8'h42);
    readReg("R3 reg0 written", 8'd0, 8'h42);
    readReg("R6 error sticky", 8'd7, 8'h01);

    rstIn = 1'b1; cyc(3); rstIn = 1'b0; cyc(3);
    readReg("R1 status after second reset", 8'd7, 8'h00);
    readReg("R1 reg0 after second reset", 8'd0, 8'h00);

    cyc(5);
    finishRun();
  end
endmodule